// File: doc/BRIEF.md
# Hardware Cursor Overlay with Edge Clipping

This block lays a small ARGB cursor image over a video pixel stream. The stream arrives one pixel per clock together with its x/y coordinates and a data-enable flag. The cursor sits at a programmable signed screen position. When the cursor hangs off the left, top, right or bottom of the active area, the block works out the part that stays on screen. It also works out where that part starts inside the bitmap. Inside the visible rectangle each stream pixel is either alpha-blended with the cursor colour or replaced by it. Every other pixel leaves the block unchanged. All pixels leave after the same fixed delay.

The cursor bitmap is held in an internal two-bank RAM. Software fills it through an address register and a data register, and the address steps forward by itself after each data write. Position, size and enable are staged in pending registers and become live together at the end of each frame. A change of size is the exception: it also turns the cursor off at once and rewinds the write address, so that the bitmap can be loaded again. An interlace setting halves the vertical placement and size and steps two bitmap rows per field line.

Top module: `cursor_overlay`

## Requirements
- R1: A size write (select 1, height in bits 31:16, width in bits 15:0) is ignored when either field exceeds 64 or both exceed 32; the cursor keeps its earlier size and enable.
- R2: With a negative x (or y) position the cursor starts at screen column (row) 0, the bitmap is read from column (row) minus the position, and the visible width (height) is the size less that offset, floored at zero.
- R3: When position plus size passes the active width (or height), the visible width (height) becomes active size minus position, floored at zero, and the bitmap is read from offset 0.
- R4: With the interlace bit (control bit 1) set, the screen y and the visible height are halved after clipping, field line k of the cursor shows bitmap row y-offset plus 2k, and a frame ends after half the active height in lines.
- R5: When the cursor is disabled or its visible width or height is zero, every output pixel equals the input pixel.
- R6: A position write (select 0, y in bits 31:16, x in bits 15:0, two's complement), a legal size and the enable (control bit 0) take effect together only when the last pixel of the last active line has been received; the frame being shown keeps the old values.
- R7: A legal size write with a new value clears both the pending and the live enable in the same cycle and rewinds the bitmap write address to the first word of bank A (address 0x0C00).
- R8: A pixel written to the data register (select 5) in A,R,G,B byte order is stored with bytes 0 and 2 swapped; stream and output pixels use lanes 23:16, 15:8 and 7:0 in that stored order, and output lane 31:24 always carries the stream value.
- R9: The write address (select 4, 14 bits) maps to bitmap word {bit 8, bits 13:12, bits 7:0}, and writes are kept only when bits 11:9 are 110. After each data write it steps by one; when its low byte wraps to zero it also advances by 0xF00; when its bits under mask 0x30FF are all zero it jumps to 0x0D00 (bank B), so loads run linearly through 2048 words and then repeat the second bank.
- R10: The output pixel and its enable follow the input by exactly two clocks; after reset both are zero.
- R11: With control bit 2 clear, each colour lane is (c*a' + p*(256-a'))>>8, where a' is the cursor alpha plus its top bit. With bit 2 set, the cursor colour replaces the pixel.
- R12: The bitmap word for a covered pixel is (bitmap row)*(cursor width) + (bitmap column), with row and column counted from the clipped start offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 position, 1 size, 2 control, 3 active area, 4 write address, 5 write data |
| wr_data | input | 32 | Register write value |
| de | input | 1 | Input pixel valid |
| px_x | input | 12 | Column of the input pixel |
| px_y | input | 12 | Line of the input pixel (field line when interlaced) |
| px_in | input | 32 | Input pixel |
| out_de | output | 1 | Output pixel valid |
| px_out | output | 32 | Composited pixel |

## Verification
The hardest case to reach is the bank switch of the write address. It only happens after more than a thousand data writes, and it shows up only as pixels in the lower half of a full-height cursor. The stimulus loads the whole 64x32 bitmap and then writes five more words. These must land on row 16 of the image, so the displayed frame shows whether the wrap went to bank B. Interlace and the immediate disable on a size change are reached the same way, by displaying frames right after the register writes. Each frame is followed by a second one, so the deferred commit is seen on both sides of the frame boundary.

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int CW        = 12,
  parameter int DW        = 7,
  parameter int MAX_LONG  = 64,
  parameter int MAX_SHORT = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [31:0]   wr_data,
  input  logic          de,
  input  logic [CW-1:0] px_x,
  input  logic [CW-1:0] px_y,
  input  logic [31:0]   px_in,
  output logic          out_de,
  output logic [31:0]   px_out
);
  localparam int DEPTH = MAX_LONG * MAX_SHORT;
  localparam int IW    = $clog2(DEPTH);
  localparam logic [13:0] BANK_A = 14'h0C00;
  localparam logic [13:0] BANK_B = 14'h0D00;
  localparam logic [2:0] S_POS = 3'd0, S_SIZE = 3'd1, S_CTRL = 3'd2,
                         S_DISP = 3'd3, S_ADDR = 3'd4, S_DATA = 3'd5;

  logic [31:0]   pos_s, pos_a;
  logic [DW-1:0] w_s, h_s, w_a, h_a;
  logic          en_s, en_a, il, rep;
  logic [CW-1:0] aw, ah;
  logic [13:0]   wa;
  logic          de_q;
  logic [CW-1:0] y_q;
  logic [31:0]   mem [DEPTH];
  logic [31:0]   cur, pix1;
  logic          de1, hit1;

  wire [15:0] nw = wr_data[15:0];
  wire [15:0] nh = wr_data[31:16];
  wire size_ok  = (nw <= 16'(MAX_LONG)) && (nh <= 16'(MAX_LONG)) &&
                  !((nw > 16'(MAX_SHORT)) && (nh > 16'(MAX_SHORT)));
  wire size_new = size_ok && ((nw[DW-1:0] != w_s) || (nh[DW-1:0] != h_s));

  wire [CW-1:0] lines = il ? (ah >> 1) : ah;
  wire frame_end = de_q && !de && (y_q == lines - CW'(1));

  wire [13:0] inc0 = wa + 14'd1;
  wire [13:0] inc1 = (inc0[7:0] == 8'd0) ? inc0 + 14'h0F00 : inc0;
  wire [13:0] wa_nxt = ((inc1 & 14'h30FF) == 14'd0) ? BANK_B : inc1;
  wire [IW-1:0] widx = {wa[8], wa[13:12], wa[7:0]};
  wire wa_ok = (wa[11:9] == 3'b110);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_s <= '0; pos_a <= '0;
      w_s <= '0; h_s <= '0; w_a <= '0; h_a <= '0;
      en_s <= 1'b0; en_a <= 1'b0; il <= 1'b0; rep <= 1'b0;
      aw <= '0; ah <= '0;
      wa <= BANK_A;
      de_q <= 1'b0; y_q <= '0;
    end else begin
      de_q <= de;
      y_q  <= px_y;
      if (frame_end) begin
        pos_a <= pos_s; w_a <= w_s; h_a <= h_s; en_a <= en_s;
      end
      if (wr_en) begin
        case (wr_sel)
          S_POS:  pos_s <= wr_data;
          S_SIZE: if (size_ok) begin
                    w_s <= nw[DW-1:0];
                    h_s <= nh[DW-1:0];
                    if (size_new) begin
                      en_s <= 1'b0; en_a <= 1'b0; wa <= BANK_A;
                    end
                  end
          S_CTRL: begin
                    en_s <= wr_data[0]; il <= wr_data[1]; rep <= wr_data[2];
                  end
          S_DISP: begin
                    aw <= wr_data[CW-1:0]; ah <= wr_data[16+CW-1:16];
                  end
          S_ADDR: wa <= wr_data[13:0];
          S_DATA: wa <= wa_nxt;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk)
    if (wr_en && wr_sel == S_DATA && wa_ok)
      mem[widx] <= {wr_data[31:24], wr_data[7:0], wr_data[15:8], wr_data[23:16]};

  function automatic logic [2*DW+CW-1:0] clip(input logic [15:0] p,
                                              input logic [DW-1:0] sz,
                                              input logic [CW-1:0] lim);
    logic signed [17:0] ps, ss, ls;
    logic [DW-1:0] off, vis;
    logic [CW-1:0] scr;
    ps  = {{2{p[15]}}, p};
    ss  = 18'(sz);
    ls  = 18'(lim);
    off = '0; scr = '0; vis = sz;
    if (ps < 0) begin
      if (-ps >= ss) vis = '0;
      else begin
        off = DW'(-ps);
        vis = sz - DW'(-ps);
      end
    end else begin
      scr = CW'(ps);
      if (ps + ss > ls) vis = (ls > ps) ? DW'(ls - ps) : '0;
    end
    return {off, scr, vis};
  endfunction

  logic [DW-1:0] xoff, xvis, yoff, yvis0;
  logic [CW-1:0] xscr, yscr0;
  assign {xoff, xscr, xvis}   = clip(pos_a[15:0],  w_a, aw);
  assign {yoff, yscr0, yvis0} = clip(pos_a[31:16], h_a, ah);
  wire [CW-1:0] yscr = il ? (yscr0 >> 1) : yscr0;
  wire [DW-1:0] yvis = il ? (yvis0 >> 1) : yvis0;

  wire en_live = en_a && (xvis != '0) && (yvis != '0);
  wire hitx = ({1'b0, px_x} >= {1'b0, xscr}) &&
              ({1'b0, px_x} <  {1'b0, xscr} + (CW+1)'(xvis));
  wire hity = ({1'b0, px_y} >= {1'b0, yscr}) &&
              ({1'b0, px_y} <  {1'b0, yscr} + (CW+1)'(yvis));
  wire hit  = en_live && de && hitx && hity;

  wire [DW-1:0] col  = xoff + DW'(px_x - xscr);
  wire [DW-1:0] row  = DW'(px_y - yscr);
  wire [DW-1:0] rowb = yoff + (il ? (row << 1) : row);
  wire [IW-1:0] ridx = IW'(rowb) * IW'(w_a) + IW'(col);

  always_ff @(posedge clk) cur <= mem[ridx];

  wire [8:0] a9 = {1'b0, cur[31:24]} + {8'd0, cur[31]};
  logic [23:0] mix;
  always_comb begin : blend
    logic [15:0] s;
    for (int i = 0; i < 3; i++) begin
      s = 16'(cur[8*i +: 8]) * 16'(a9) + 16'(pix1[8*i +: 8]) * 16'(9'd256 - a9);
      mix[8*i +: 8] = rep ? cur[8*i +: 8] : 8'(s >> 8);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix1 <= '0; de1 <= 1'b0; hit1 <= 1'b0;
      out_de <= 1'b0; px_out <= '0;
    end else begin
      pix1   <= px_in;
      de1    <= de;
      hit1   <= hit;
      out_de <= de1;
      px_out <= hit1 ? {pix1[31:24], mix} : pix1;
    end
  end
endmodule

module cursor_overlay_chk #(
  parameter int DW        = 7,
  parameter int MAX_LONG  = 64,
  parameter int MAX_SHORT = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          de,
  input logic [31:0]   px_in,
  input logic          out_de,
  input logic [31:0]   px_out,
  input logic          en_live,
  input logic          en_a,
  input logic          frame_end,
  input logic [31:0]   pos_a,
  input logic [DW-1:0] w_s,
  input logic [DW-1:0] h_s
);
  logic [1:0] cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= 2'd0;
    else if (cnt != 2'd2) cnt <= cnt + 2'd1;

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd2) |-> (out_de == $past(de, 2)));

  assert_passthrough_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd2 && !$past(en_live, 2)) |-> (px_out == $past(px_in, 2)));

  assert_enable_at_frame_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_a) |-> $past(frame_end));

  assert_position_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 2'd0 && !$past(frame_end)) |-> $stable(pos_a));

  assert_size_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (w_s <= DW'(MAX_LONG)) && (h_s <= DW'(MAX_LONG)) &&
    !((w_s > DW'(MAX_SHORT)) && (h_s > DW'(MAX_SHORT))));
endmodule

bind cursor_overlay cursor_overlay_chk #(.DW(DW), .MAX_LONG(MAX_LONG), .MAX_SHORT(MAX_SHORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .de(de), .px_in(px_in), .out_de(out_de),
  .px_out(px_out), .en_live(en_live), .en_a(en_a), .frame_end(frame_end),
  .pos_a(pos_a), .w_s(w_s), .h_s(h_s));

// File: tb/cursor_overlay_tb.sv
module cursor_overlay_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic wr_en = 1'b0; logic [2:0] wr_sel = '0; logic [31:0] wr_data = '0;
  logic de = 1'b0; logic [11:0] px_x = '0, px_y = '0; logic [31:0] px_in = '0;
  logic out_de; logic [31:0] px_out;

  cursor_overlay u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .de(de), .px_x(px_x), .px_y(px_y), .px_in(px_in),
    .out_de(out_de), .px_out(px_out));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  int s_x, s_y, s_w, s_h, a_x, a_y, a_w, a_h, m_aw, m_ah, ptr, fno;
  bit s_en, a_en, m_il, m_rep;
  logic [31:0] bm [2048];

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_pos(input int x, input int y);
    wr(3'd0, {y[15:0], x[15:0]}); s_x = x; s_y = y;
  endtask

  task automatic set_size(input int w, input int h);
    bit ok;
    ok = (w <= 64) && (h <= 64) && !((w > 32) && (h > 32));
    wr(3'd1, {h[15:0], w[15:0]});
    if (ok) begin
      if (w != s_w || h != s_h) begin s_en = 0; a_en = 0; ptr = 0; end
      s_w = w; s_h = h;
    end
  endtask

  task automatic set_ctrl(input bit en, input bit il, input bit rp);
    wr(3'd2, {29'd0, rp, il, en}); s_en = en; m_il = il; m_rep = rp;
  endtask

  task automatic put_pix(input logic [31:0] d);
    wr(3'd5, d);
    bm[ptr] = {d[31:24], d[7:0], d[15:8], d[23:16]};
    ptr = (ptr == 2047) ? 1024 : ptr + 1;
  endtask

  function automatic void clip1(input int p, input int sz, input int lim,
                                output int off, output int scr, output int vis);
    if (p < 0) begin
      scr = 0; off = -p; vis = (off >= sz) ? 0 : sz - off;
    end else if (p + sz > lim) begin
      off = 0; scr = p; vis = (lim > p) ? lim - p : 0;
    end else begin
      off = 0; scr = p; vis = sz;
    end
  endfunction

  function automatic logic [31:0] expect_pix(input int x, input int y, input logic [31:0] p);
    int xo, xs, xv, yo, ys, yv, idx, a, a9;
    logic [31:0] c;
    logic [23:0] ln;
    clip1(a_x, a_w, m_aw, xo, xs, xv);
    clip1(a_y, a_h, m_ah, yo, ys, yv);
    if (m_il) begin ys = ys / 2; yv = yv / 2; end
    if (!a_en || xv == 0 || yv == 0) return p;
    if (x < xs || x >= xs + xv || y < ys || y >= ys + yv) return p;
    idx = (yo + (y - ys) * (m_il ? 2 : 1)) * a_w + xo + (x - xs);
    c = bm[idx];
    a = int'(c[31:24]); a9 = a + (a >> 7);
    for (int i = 0; i < 3; i++) begin
      if (m_rep) ln[8*i +: 8] = c[8*i +: 8];
      else ln[8*i +: 8] = 8'((int'(c[8*i +: 8]) * a9 + int'(p[8*i +: 8]) * (256 - a9)) >> 8);
    end
    return {p[31:24], ln};
  endfunction

  task automatic frame(input string tag);
    int lines;
    logic [31:0] pv;
    lines = m_il ? m_ah / 2 : m_ah;
    for (int y = 0; y < lines; y++) begin
      for (int x = 0; x < m_aw; x++) begin
        pv = {8'hC3, 8'(x * 5 + fno), 8'(y * 9), 8'(x ^ y)};
        @(negedge clk); de = 1'b1; px_x = 12'(x); px_y = 12'(y); px_in = pv;
        exp_q.push_back(expect_pix(x, y, pv));
        tag_q.push_back(tag);
      end
      @(negedge clk); de = 1'b0;
      repeat (3) @(negedge clk);
    end
    a_x = s_x; a_y = s_y; a_w = s_w; a_h = s_h; a_en = s_en;
    fno++;
    repeat (4) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_de) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected output actual=%h expected=none", px_out);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        checks++;
        if (px_out !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", t, px_out, e);
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] bmv(input int k);
    logic [7:0] al;
    al = (k % 3 == 0) ? 8'hFF : ((k % 3 == 1) ? 8'h80 : 8'h00);
    return {al, 8'(k), 8'(k >> 3) ^ 8'h5A, 8'h30 + 8'(k & 63)};
  endfunction

  initial begin
    s_x = 0; s_y = 0; s_w = 0; s_h = 0; s_en = 0;
    a_x = 0; a_y = 0; a_w = 0; a_h = 0; a_en = 0;
    m_aw = 0; m_ah = 0; m_il = 0; m_rep = 0; ptr = 0; fno = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_de !== 1'b0 || px_out !== 32'd0) begin
      errors++;
      $display("FAIL R10 reset state actual=%b/%h expected=0/00000000", out_de, px_out);
    end

    wr(3'd3, {16'd40, 16'd80}); m_aw = 80; m_ah = 40;
    set_size(64, 32);
    wr(3'd4, 32'h0000_0C00); ptr = 0;
    for (int k = 0; k < 2048; k++) put_pix(bmv(k));
    for (int i = 0; i < 5; i++) put_pix({8'hFF, 8'hE0 + 8'(i), 8'h11, 8'h22});

    set_ctrl(1, 0, 0); set_pos(10, 4);
    frame("R6 pending not shown");
    frame("R9 R11 R12 blend");
    set_pos(-5, -3);
    frame("R6 old position");
    frame("R2 negative clip");
    set_pos(70, 30);
    frame("R6");
    frame("R3 edge clip");
    set_pos(90, 10);
    frame("R3");
    frame("R5 R10 zero width");
    set_ctrl(1, 0, 1); set_pos(0, 0);
    frame("R11");
    frame("R8 R11 replace");
    set_size(40, 40);
    set_size(10, 65);
    frame("R1 illegal size ignored");
    set_ctrl(1, 1, 0); set_pos(3, 5);
    frame("R4 interlace old position");
    frame("R4 interlace");
    set_ctrl(1, 0, 0);
    set_size(16, 16);
    frame("R7 size change disables");
    for (int i = 0; i < 4; i++) put_pix({8'hFF, 8'h01 + 8'(i), 8'h02, 8'h03});
    set_ctrl(1, 0, 0);
    frame("R7");
    frame("R7 R12 reload stride 16");

    repeat (10) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 missing outputs actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule